// File: doc/BRIEF.md
# Lockable Clock-Generator Control Register

This block is a small indexed configuration space on a byte-wide index/data host bus. It holds two registers. One is an identification register that returns a fixed family code and a revision code. The other is a clock-generator control register. That register has a generator enable bit, which software can only set, and a read-only clock-valid status bit. The enable bit can be written only while it is still clear. Once software sets it, every bit of that register ignores writes until a hardware reset.

A lock-detect stage stands in for the real oscillator or PLL. It watches a lock indication from the generator. It declares the clock valid only after the enable is set and the lock indication has stayed high for a set number of consecutive reference cycles. The clock-valid status drives the gated clock-enable output directly. Downstream logic therefore sees no clock until the generator is known to be good. When lock is lost, the output drops at once.

The reset input asserts asynchronously and is released through a synchronizer. Reads are combinational on the presented index. Writes take effect at the clock edge where the write strobe is high.

Top module: `ccg_clkgen_ctrl`

## Requirements
- R1: After reset, the control register at index 8'h29 reads 8'h00 and clk_out_en is 0.
- R2: A write to index 8'h29 with data bit 7 = 1 sets the enable. From the next cycle the register reads with bit 7 = 1.
- R3: While the enable is 0, a write to index 8'h29 with data bit 7 = 0 leaves the enable at 0.
- R4: Once the enable is 1, no write to index 8'h29 changes any bit of the register. Only reset clears the enable.
- R5: Bits 6, 5 and 3 to 0 of the control register always read 0, whatever was written.
- R6: Bit 4 of the control register (clock valid) reads 1 once the enable is 1 and lock_in has been sampled high on LOCK_CYCLES consecutive rising edges. It stays 0 after only LOCK_CYCLES-1 such edges.
- R7: Clock valid falls in the same cycle that lock_in goes low. Validity then needs a fresh run of LOCK_CYCLES consecutive lock edges.
- R8: clk_out_en always equals the clock-valid bit. With the enable at 0 it stays 0, even while lock_in is held high.
- R9: Index 8'h27 reads {3'b000, REVISION}, with the family code in bits 7 to 5 and the revision parameter in bits 4 to 0. Writes to it have no effect.
- R10: Any index other than 8'h27 and 8'h29 reads 8'h00, and writes to it change nothing.
- R11: Driving rst_n low clears the enable and clk_out_en without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low hardware reset, asserts asynchronously |
| host_we | input | 1 | Write strobe for the presented index |
| host_idx | input | 8 | Register index |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_idx, combinational |
| lock_in | input | 1 | Lock indication from the generator |
| clk_out_en | output | 1 | Gated clock enable for the generated clock |

## Verification
Read data is combinational, so a register's new value is visible at the falling edge that follows the write's rising edge. Every table row drives a write at a falling edge, lets exactly one rising edge pass, and then switches the index and samples at the next falling edge. The clock-valid result depends on how many lock edges have been sampled since the enable edge. The bench counts those edges itself and checks one edge before the threshold as well as at it. Loss of lock and asynchronous reset act without a clock edge, so those checks sample a moment after the input change and before any rising edge.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned IDX_W    = 8;
  localparam logic [IDX_W-1:0] IDX_IDENT = 8'h27;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 8'h29;
  localparam int unsigned EN_POS    = 7;
  localparam int unsigned VALID_POS = 4;
  localparam int unsigned FAMILY_W  = 3;
  localparam int unsigned REV_W     = DATA_W - FAMILY_W;
  localparam logic [FAMILY_W-1:0] FAMILY_CODE = 3'b000;
endpackage

// File: rtl/ccg_rst_sync.sv
module ccg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/ccg_lock_detect.sv
module ccg_lock_detect #(
  parameter int unsigned LOCK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_en,
  input  logic lock_in,
  output logic clk_valid
);
  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;
  logic             run;

  always_comb begin
    run    = gen_en && lock_in;
    cnt_ce = !run || (cnt_q != CNT_LIM);
    cnt_d  = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign clk_valid = run && (cnt_q == CNT_LIM);

  // R6: validity can only appear after lock was sampled high
  assert_valid_after_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_valid) |-> $past(lock_in));
  // R7: a lock loss forces a new count, so no validity on the next cycle
  assert_restart_after_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_in |=> !clk_valid);
endmodule

// File: rtl/ccg_cfg_regs.sv
module ccg_cfg_regs
  import ccg_pkg::*;
#(
  parameter logic [REV_W-1:0] REVISION = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              clk_valid,
  output logic              gen_en,
  output logic [DATA_W-1:0] host_rdata
);
  logic en_q;
  logic en_d;
  logic en_ce;
  logic ctrl_wr;

  always_comb begin
    ctrl_wr = host_we && (host_idx == IDX_CTRL);
    en_ce   = ctrl_wr && !en_q && host_wdata[EN_POS];
    en_d    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  always_comb begin
    host_rdata = '0;
    unique case (host_idx)
      IDX_IDENT: host_rdata = {FAMILY_CODE, REVISION};
      IDX_CTRL: begin
        host_rdata[EN_POS]    = en_q;
        host_rdata[VALID_POS] = clk_valid;
      end
      default: host_rdata = '0;
    endcase
  end

  assign gen_en = en_q;

  // R2: a set write takes effect on the next cycle
  assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_idx == IDX_CTRL && host_wdata[EN_POS]) |=> en_q);
  // R3: writing zero to a clear enable keeps it clear
  assert_zero_write_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_idx == IDX_CTRL && !host_wdata[EN_POS] && !en_q) |=> !en_q);
  // R4: once set, the enable stays set until reset
  assert_enable_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
endmodule

// File: rtl/ccg_clkgen_ctrl.sv
module ccg_clkgen_ctrl
  import ccg_pkg::*;
#(
  parameter int unsigned       LOCK_CYCLES = 64,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [REV_W-1:0]  REVISION    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              lock_in,
  output logic              clk_out_en
);
  logic rst_sync_n;
  logic gen_en;
  logic clk_valid;

  ccg_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ccg_cfg_regs #(.REVISION(REVISION)) cfg_regs_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_we    (host_we),
    .host_idx   (host_idx),
    .host_wdata (host_wdata),
    .clk_valid  (clk_valid),
    .gen_en     (gen_en),
    .host_rdata (host_rdata)
  );

  ccg_lock_detect #(.LOCK_CYCLES(LOCK_CYCLES)) lock_det_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .gen_en    (gen_en),
    .lock_in   (lock_in),
    .clk_valid (clk_valid)
  );

  assign clk_out_en = clk_valid;

  // R8: the clock enable agrees with the status bit read by the host
  assert_clken_matches_status_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_idx == IDX_CTRL) |-> (clk_out_en == host_rdata[VALID_POS]));
  // R5: reserved positions of the control register read zero
  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_idx == IDX_CTRL) |-> (host_rdata[6:5] == 2'b00 && host_rdata[3:0] == 4'h0));
  // R10: unmapped indexes read zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_idx != IDX_CTRL && host_idx != IDX_IDENT) |-> (host_rdata == '0));
endmodule

// File: tb/ccg_clkgen_ctrl_tb_top.sv
module ccg_clkgen_ctrl_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned TB_LOCK    = 3;
  localparam logic [4:0]  TB_REV     = 5'h0B;

  typedef struct packed {
    logic       we;
    logic [7:0] widx;
    logic [7:0] wdata;
    logic       lock;
    logic [7:0] ridx;
    logic [7:0] exp_rd;
    logic       exp_en;
  } vec_t;

  localparam int unsigned NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'h29, 8'h00, 1'b0}, // R1 idle after reset
    '{1'b1, 8'h27, 8'hFF, 1'b0, 8'h27, 8'h0B, 1'b0}, // R9 ident ignores write
    '{1'b1, 8'h29, 8'h7F, 1'b0, 8'h29, 8'h00, 1'b0}, // R3 R5 zero in bit 7
    '{1'b1, 8'h40, 8'hAA, 1'b0, 8'h40, 8'h00, 1'b0}, // R10 unmapped
    '{1'b1, 8'h29, 8'h80, 1'b0, 8'h29, 8'h80, 1'b0}, // R2 enable set
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h29, 8'h80, 1'b0}, // R6 lock edge 1
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h29, 8'h80, 1'b0}, // R6 lock edge 2
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h29, 8'h90, 1'b1}, // R6 lock edge 3 valid
    '{1'b1, 8'h29, 8'h00, 1'b1, 8'h29, 8'h90, 1'b1}, // R4 clear attempt
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'h29, 8'h80, 1'b0}, // R7 lock lost
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h29, 8'h80, 1'b0}, // R7 restart 1
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h29, 8'h80, 1'b0}, // R7 restart 2
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'h29, 8'h80, 1'b0}, // R7 interrupted
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h29, 8'h80, 1'b0}, // R7 fresh 1
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h29, 8'h80, 1'b0}, // R7 fresh 2
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h29, 8'h90, 1'b1}, // R7 fresh 3 valid
    '{1'b1, 8'h29, 8'hFF, 1'b1, 8'h29, 8'h90, 1'b1}  // R4 R5 all-ones write
  };

  logic       clk;
  logic       rst_n;
  logic       host_we;
  logic [7:0] host_idx;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       lock_in;
  logic       clk_out_en;

  int n_cmp;
  int n_bad;

  ccg_clkgen_ctrl #(.LOCK_CYCLES(TB_LOCK), .REVISION(TB_REV)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_idx   (host_idx),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .lock_in    (lock_in),
    .clk_out_en (clk_out_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; host_we = 1'b0; host_idx = 8'h29; host_wdata = 8'h00; lock_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      host_we = VECS[i].we; host_idx = VECS[i].widx;
      host_wdata = VECS[i].wdata; lock_in = VECS[i].lock;
      @(posedge clk);
      @(negedge clk);
      host_we = 1'b0; host_idx = VECS[i].ridx;
      #1;
      chk($sformatf("R1-table row %0d rdata", i), host_rdata, VECS[i].exp_rd);
      chk($sformatf("R8 table row %0d clk_out_en", i), {7'd0, clk_out_en}, {7'd0, VECS[i].exp_en});
    end

    // R11: asynchronous reset clears state with no clock edge
    #2;
    rst_n = 1'b0;
    #1;
    host_idx = 8'h29;
    #0;
    chk("R11 rdata during reset", host_rdata, 8'h00);
    chk("R11 clk_out_en during reset", {7'd0, clk_out_en}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: lock held high without enable never validates
    lock_in = 1'b1;
    repeat (8) @(negedge clk);
    #1;
    chk("R8 lock only rdata", host_rdata, 8'h00);
    chk("R8 lock only clk_out_en", {7'd0, clk_out_en}, 8'h00);

    // R6: boundary one edge below and at the threshold
    host_we = 1'b1; host_wdata = 8'h80;
    @(posedge clk);
    @(negedge clk);
    host_we = 1'b0;
    repeat (TB_LOCK - 1) @(negedge clk);
    #1;
    chk("R6 one edge short", {7'd0, clk_out_en}, 8'h00);
    @(negedge clk);
    #1;
    chk("R6 at threshold", {7'd0, clk_out_en}, 8'h01);
    chk("R6 status read", host_rdata, 8'h90);

    // R7: immediate drop when lock falls, no edge needed
    lock_in = 1'b0;
    #1;
    chk("R7 combinational drop", {7'd0, clk_out_en}, 8'h00);

    finish_run();
  end
endmodule